// File: doc/BRIEF.md
# List-Driven Bus Read-Out Sequencer

This block reads out a crate of slave modules without the host touching each bus cycle. The host first loads a command list into a small synchronous RAM. It then pulses a trigger. The sequencer walks the list from its first entry. Each entry becomes one action on a simplified backplane master port: a primary address cycle, a secondary address cycle, a single write, a single read, or a block of reads. Every word that is read goes out on a valid/ready stream toward a downstream filtering stage.

A run ends in one of three ways:
- An END entry in the list.
- A slave answering a read with status code 2, which marks the last data word.
- An error: no acknowledge within the programmed timeout, or an undefined opcode.

In every case the sequencer first waits until the downstream pipeline reports itself idle. It then drops busy and raises an interrupt. The interrupt stays set until the host clears it. A separate error flag tells the host which kind of end occurred.

Top module: `list_readout_seq`

## Requirements
- R1: After reset, busy, irq, err_end, all strobes and out_valid are low, and the block stays idle, with no strobe, until start is pulsed.
- R2: A list word has its opcode in bits [30:28], a word count in [27:16] and an operand in [15:0]. Opcodes: 0 END, 1 primary address, 2 secondary address, 3 read, 4 write, 5 block read. A run executes the entries in order from list address 0.
- R3: A primary cycle asserts bm_as with bm_sec low. A secondary cycle asserts bm_as with bm_sec high. A write asserts bm_ds with bm_wr high. Each of these drives bm_ad = {16'h0, operand} and holds its strobe until bm_ack.
- R4: A read asserts bm_ds with bm_wr low and forwards the bm_rdata captured on bm_ack as one stream word.
- R5: A block read performs as many read cycles as its count field gives, forwarding each word in order. A count of 0 performs no cycle.
- R6: While out_valid is high and out_ready low, out_valid and out_data hold, and no bus cycle starts. No word is lost or duplicated.
- R7: A read acknowledged with bm_ss == 2 ends the run normally after that word is forwarded. List entries after it are not executed.
- R8: An END entry ends the run normally, with err_end low.
- R9: If a strobe sees no bm_ack in timeout_limit+1 consecutive cycles, the run ends with err_end high. An opcode of 6 or 7 also ends the run with err_end high.
- R10: After any end, irq rises and busy falls on the same edge. This happens only after pipe_idle has been high, so no irq is raised while the downstream stage is busy.
- R11: irq and err_end stay set until an irq_clr pulse clears both.
- R12: A start pulse while busy is ignored. The run is not restarted and the list is not re-executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lm_we | input | 1 | List memory write enable |
| lm_waddr | input | LIST_AW | List memory write address |
| lm_wdata | input | 31 | List word to store |
| start | input | 1 | Run trigger from the host |
| irq_clr | input | 1 | Clears irq and err_end |
| timeout_limit | input | TW | Acknowledge timeout, in cycles minus one |
| bm_as | output | 1 | Address strobe |
| bm_sec | output | 1 | Secondary address qualifier for bm_as |
| bm_ds | output | 1 | Data strobe |
| bm_wr | output | 1 | Write direction for a data cycle |
| bm_ad | output | DW | Address or write data driven to the slave |
| bm_ack | input | 1 | Slave acknowledge |
| bm_ss | input | 3 | Slave status code, sampled with bm_ack on reads |
| bm_rdata | input | DW | Slave read data |
| out_data | output | DW | Stream data |
| out_valid | output | 1 | Stream valid |
| out_ready | input | 1 | Stream ready from downstream |
| pipe_idle | input | 1 | Downstream stages have nothing in flight |
| busy | output | 1 | A run is active |
| irq | output | 1 | Completion interrupt, sticky |
| err_end | output | 1 | The last run ended on an error, sticky |

## Verification
The bench targets the following corner cases, each with the failure it exposes:
- **Status code 2 inside a block.** A block read stops on this code and the list carries a write after it. A sequencer that kept going would show an extra slave write, or extra stream words.
- **Acknowledge on the last allowed cycle versus never.** A slave acknowledges exactly on cycle timeout_limit, and elsewhere never acknowledges. An off-by-one counter either flags a good cycle as an error or lets a dead cycle through.
- **Slow downstream.** A downstream stage holds pipe_idle low for many cycles after the final word. An interrupt raised early shows up as too short a gap between the last accept and irq.
- **Start during a run, and awkward counts.** A start pulse arrives in mid-run, and some blocks have a count of 0. A design that restarts on the pulse, or reads once on a count of 0, produces an address log or word count that differs from the model.

// File: rtl/list_readout_seq.sv
module list_readout_seq #(
  parameter int LIST_AW = 6,
  parameter int DW      = 32,
  parameter int TW      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lm_we,
  input  logic [LIST_AW-1:0] lm_waddr,
  input  logic [30:0]        lm_wdata,
  input  logic               start,
  input  logic               irq_clr,
  input  logic [TW-1:0]      timeout_limit,
  output logic               bm_as,
  output logic               bm_sec,
  output logic               bm_ds,
  output logic               bm_wr,
  output logic [DW-1:0]      bm_ad,
  input  logic               bm_ack,
  input  logic [2:0]         bm_ss,
  input  logic [DW-1:0]      bm_rdata,
  output logic [DW-1:0]      out_data,
  output logic               out_valid,
  input  logic               out_ready,
  input  logic               pipe_idle,
  output logic               busy,
  output logic               irq,
  output logic               err_end
);
  localparam int OPW    = 16;
  localparam int CW     = 12;
  localparam int LW     = OPW + CW + 3;
  localparam int LDEPTH = 1 << LIST_AW;

  localparam logic [2:0] OP_END = 3'd0;
  localparam logic [2:0] OP_PRI = 3'd1;
  localparam logic [2:0] OP_SEC = 3'd2;
  localparam logic [2:0] OP_RD  = 3'd3;
  localparam logic [2:0] OP_WR  = 3'd4;
  localparam logic [2:0] OP_BLK = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DEC, S_BUS, S_PUSH, S_DRAIN} st_t;

  st_t                st;
  logic [LW-1:0]      mem [LDEPTH];
  logic [LW-1:0]      mem_q;
  logic [LIST_AW-1:0] pc;
  logic [2:0]         op;
  logic [OPW-1:0]     arg;
  logic [CW-1:0]      rem;
  logic [TW-1:0]      tcnt;
  logic               last;

  logic [2:0]     q_op;
  logic [CW-1:0]  q_cnt;
  logic [OPW-1:0] q_arg;
  logic           is_rd, in_bus;

  assign q_op  = mem_q[LW-1 -: 3];
  assign q_cnt = mem_q[OPW +: CW];
  assign q_arg = mem_q[OPW-1:0];

  assign is_rd  = (op == OP_RD) || (op == OP_BLK);
  assign in_bus = (st == S_BUS);

  assign bm_as     = in_bus && ((op == OP_PRI) || (op == OP_SEC));
  assign bm_sec    = in_bus && (op == OP_SEC);
  assign bm_ds     = in_bus && (is_rd || (op == OP_WR));
  assign bm_wr     = in_bus && (op == OP_WR);
  assign bm_ad     = (in_bus && !is_rd) ? {{(DW-OPW){1'b0}}, arg} : '0;
  assign out_valid = (st == S_PUSH);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (lm_we) mem[lm_waddr] <= lm_wdata;
    mem_q <= mem[pc];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pc       <= '0;
      op       <= OP_END;
      arg      <= '0;
      rem      <= '0;
      tcnt     <= '0;
      last     <= 1'b0;
      out_data <= '0;
      irq      <= 1'b0;
      err_end  <= 1'b0;
    end else begin
      if (irq_clr) begin
        irq     <= 1'b0;
        err_end <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          pc <= '0;
          st <= S_FETCH;
        end
        S_FETCH: st <= S_DEC;
        S_DEC: begin
          op   <= q_op;
          arg  <= q_arg;
          pc   <= pc + 1'b1;
          tcnt <= '0;
          last <= 1'b0;
          case (q_op)
            OP_END: st <= S_DRAIN;
            OP_PRI, OP_SEC, OP_RD, OP_WR: begin
              rem <= CW'(1);
              st  <= S_BUS;
            end
            OP_BLK: begin
              rem <= q_cnt;
              st  <= (q_cnt == '0) ? S_FETCH : S_BUS;
            end
            default: begin
              err_end <= 1'b1;
              st      <= S_DRAIN;
            end
          endcase
        end
        S_BUS: begin
          if (bm_ack) begin
            tcnt <= '0;
            if (is_rd) begin
              out_data <= bm_rdata;
              last     <= (bm_ss == 3'd2);
              st       <= S_PUSH;
            end else begin
              st <= S_FETCH;
            end
          end else if (tcnt == timeout_limit) begin
            err_end <= 1'b1;
            st      <= S_DRAIN;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_PUSH: if (out_ready) begin
          if (last) begin
            st <= S_DRAIN;
          end else if (rem > CW'(1)) begin
            rem <= rem - 1'b1;
            st  <= S_BUS;
          end else begin
            st <= S_FETCH;
          end
        end
        S_DRAIN: if (pipe_idle) begin
          irq <= 1'b1;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/list_readout_seq_chk.sv
module list_readout_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          bm_as,
  input logic          bm_ds,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          irq,
  input logic          irq_clr,
  input logic          pipe_idle,
  input logic          err_end
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bm_as && !bm_ds && !out_valid));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bm_as && bm_ds));

  // R6
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  no_bus_in_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!bm_as && !bm_ds));

  // R10
  irq_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(pipe_idle) && $past(busy) && !busy));

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

  // R9
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_end |-> (irq || busy));
endmodule

bind list_readout_seq list_readout_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bm_as(bm_as), .bm_ds(bm_ds),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .irq(irq), .irq_clr(irq_clr), .pipe_idle(pipe_idle), .err_end(err_end)
);

// File: tb/sim_list_readout_seq.sv
module sim_list_readout_seq;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int NONE  = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lm_we = 1'b0;
  logic [AW-1:0] lm_waddr = '0;
  logic [30:0]   lm_wdata = '0;
  logic          start = 1'b0, irq_clr = 1'b0;
  logic [15:0]   timeout_limit = 16'd5;
  logic          bm_as, bm_sec, bm_ds, bm_wr;
  logic [31:0]   bm_ad;
  logic          bm_ack = 1'b0;
  logic [2:0]    bm_ss = 3'd0;
  logic [31:0]   bm_rdata = '0;
  logic [31:0]   out_data;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          pipe_idle;
  logic          busy, irq, err_end;

  list_readout_seq #(.LIST_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .lm_we(lm_we), .lm_waddr(lm_waddr), .lm_wdata(lm_wdata),
    .start(start), .irq_clr(irq_clr), .timeout_limit(timeout_limit),
    .bm_as(bm_as), .bm_sec(bm_sec), .bm_ds(bm_ds), .bm_wr(bm_wr), .bm_ad(bm_ad),
    .bm_ack(bm_ack), .bm_ss(bm_ss), .bm_rdata(bm_rdata),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .pipe_idle(pipe_idle),
    .busy(busy), .irq(irq), .err_end(err_end));

  always #(CLK_P/2) clk = ~clk;

  int vec = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  // slave, sink and list state
  int sl_delay = 0, sl_cnt = 0, sl_nbus = 0, sl_nread = 0;
  int sl_dead_at = NONE, sl_ss_at = NONE;
  logic [17:0] lg [64];
  int nlg = 0;
  int nrx = 0, rdy_pct = 100, pipe_k = 0, pipe_cnt = 0, acc_cyc = 0;
  bit hold_prev = 1'b0;
  logic [31:0] hold_data = '0;
  bit strobe_seen = 1'b0;
  logic [30:0] lst [64];
  int nlst = 0;
  logic [17:0] exp_lg [64];
  int exp_nlg, exp_reads;
  bit exp_err;

  assign pipe_idle = (pipe_cnt == 0);

  function automatic logic [31:0] dat(input int n);
    return 32'h5A00_0000 ^ (n * 32'h0123_4567 + n);
  endfunction

  function automatic logic [30:0] mk(input int op, input int cnt, input int a);
    return {3'(op), 12'(cnt), 16'(a)};
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint ex);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, ex);
    end
  endtask

  function automatic void model();
    int pc = 0, bus = 0, n;
    bit stop = 1'b0;
    exp_nlg = 0; exp_reads = 0; exp_err = 1'b0;
    for (int step = 0; step < 200 && !stop; step++) begin
      logic [30:0] w = lst[pc % 64];
      pc++;
      case (w[30:28])
        3'd0: stop = 1'b1;
        3'd1, 3'd2, 3'd4: begin
          if (bus >= sl_dead_at) begin exp_err = 1'b1; stop = 1'b1; end
          else begin
            exp_lg[exp_nlg % 64] = {(w[30:28] == 3'd4) ? 2'd3 : w[29:28], w[15:0]};
            exp_nlg++; bus++;
          end
        end
        3'd3, 3'd5: begin
          n = (w[30:28] == 3'd3) ? 1 : int'(w[27:16]);
          for (int i = 0; i < n && !stop; i++) begin
            if (bus >= sl_dead_at) begin exp_err = 1'b1; stop = 1'b1; end
            else begin
              exp_reads++; bus++;
              if (exp_reads - 1 == sl_ss_at) stop = 1'b1;
            end
          end
        end
        default: begin exp_err = 1'b1; stop = 1'b1; end
      endcase
    end
  endfunction

  always @(posedge clk) cyc++;

  // slave model
  always @(negedge clk) begin
    if (bm_as || bm_ds) begin
      strobe_seen = 1'b1;
      if (sl_nbus < sl_dead_at && sl_cnt == sl_delay) begin
        bm_ack = 1'b1;
        if (bm_ds && !bm_wr) begin
          bm_rdata = dat(sl_nread);
          bm_ss = (sl_nread == sl_ss_at) ? 3'd2 : 3'd0;
          sl_nread++;
        end else begin
          if (nlg < 64) lg[nlg] = {bm_as ? (bm_sec ? 2'd2 : 2'd1) : 2'd3, bm_ad[15:0]};
          nlg++;
        end
        sl_nbus++;
      end else begin
        bm_ack = 1'b0;
      end
      sl_cnt++;
    end else begin
      bm_ack = 1'b0;
      sl_cnt = 0;
    end
  end

  // downstream sink
  always @(negedge clk) begin
    if (hold_prev)
      chk(out_valid && out_data == hold_data, "R6 hold", out_data, hold_data);
    if (pipe_cnt > 0) pipe_cnt--;
    out_ready = ($urandom_range(0, 99) < rdy_pct);
    hold_prev = out_valid && !out_ready;
    hold_data = out_data;
    if (out_valid && out_ready) begin
      chk(out_data == dat(nrx), "R4/R5 data", out_data, dat(nrx));
      nrx++;
      pipe_cnt = pipe_k;
      acc_cyc = cyc;
    end
  end

  task automatic run(input string tag, input bit mid_start);
    int guard = 0;
    for (int i = 0; i < nlst; i++) begin
      @(negedge clk);
      lm_we = 1'b1; lm_waddr = AW'(i); lm_wdata = lst[i];
    end
    @(negedge clk);
    lm_we = 1'b0;
    sl_cnt = 0; sl_nbus = 0; sl_nread = 0; nlg = 0; nrx = 0;
    model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (6) @(negedge clk);
      chk(busy, "R12 busy mid-run", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!irq && guard < 20000) begin @(negedge clk); guard++; end
    chk(irq, {tag, " R10 irq"}, irq, 1);
    if (pipe_k > 0 && nrx > 0)
      chk(cyc - acc_cyc > pipe_k, {tag, " R10 drain wait"}, cyc - acc_cyc, pipe_k + 1);
    chk(!busy, {tag, " R10 busy"}, busy, 0);
    chk(nrx == exp_reads, {tag, " R5/R7 word count"}, nrx, exp_reads);
    chk(nlg == exp_nlg, {tag, " R3/R12 cycle count"}, nlg, exp_nlg);
    for (int i = 0; i < nlg && i < exp_nlg && i < 64; i++)
      chk(lg[i] == exp_lg[i], {tag, " R2/R3 cycle"}, lg[i], exp_lg[i]);
    chk(err_end == exp_err, {tag, " R8/R9 err_end"}, err_end, exp_err);
    repeat (3) @(negedge clk);
    chk(irq && err_end == exp_err, {tag, " R11 sticky"}, {irq, err_end}, {1'b1, exp_err});
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(!irq && !err_end, {tag, " R11 clear"}, {irq, err_end}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !err_end && !out_valid && !bm_as && !bm_ds, "R1 reset", {busy, irq, err_end}, 0);
    strobe_seen = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && !strobe_seen, "R1 idle without start", {busy, strobe_seen}, 0);

    // all single-cycle kinds, END
    sl_delay = 0;
    lst[0] = mk(1, 0, 16'h1234); lst[1] = mk(2, 0, 16'h0042); lst[2] = mk(4, 0, 16'hBEEF);
    lst[3] = mk(3, 0, 0); lst[4] = mk(0, 0, 0); nlst = 5;
    run("basic", 1'b0);

    // block count 0 then 4, backpressure
    rdy_pct = 30; sl_delay = 2;
    lst[0] = mk(1, 0, 7); lst[1] = mk(5, 0, 0); lst[2] = mk(5, 4, 0); lst[3] = mk(0, 0, 0); nlst = 4;
    run("block", 1'b0);

    // status 2 mid-block, later write must not happen
    rdy_pct = 60; sl_ss_at = 2;
    lst[0] = mk(5, 6, 0); lst[1] = mk(4, 0, 16'h00AA); lst[2] = mk(0, 0, 0); nlst = 3;
    run("ss2", 1'b0);
    sl_ss_at = NONE;

    // acknowledge on the last allowed cycle
    sl_delay = 5;
    lst[0] = mk(1, 0, 3); lst[1] = mk(3, 0, 0); lst[2] = mk(0, 0, 0); nlst = 3;
    run("tmo edge", 1'b0);

    // dead slave -> timeout error
    sl_delay = 1; sl_dead_at = 1;
    lst[0] = mk(1, 0, 3); lst[1] = mk(3, 0, 0); lst[2] = mk(4, 0, 9); lst[3] = mk(0, 0, 0); nlst = 4;
    run("timeout", 1'b0);
    sl_dead_at = NONE;

    // illegal opcode
    lst[0] = mk(2, 0, 5); lst[1] = mk(7, 0, 0); lst[2] = mk(4, 0, 1); nlst = 3;
    run("illegal", 1'b0);

    // slow downstream
    pipe_k = 20; rdy_pct = 100;
    lst[0] = mk(3, 0, 0); lst[1] = mk(0, 0, 0); nlst = 2;
    run("drain", 1'b0);
    pipe_k = 0;

    // start while busy
    rdy_pct = 40;
    lst[0] = mk(1, 0, 1); lst[1] = mk(5, 5, 0); lst[2] = mk(2, 0, 2); lst[3] = mk(0, 0, 0); nlst = 4;
    run("restart", 1'b1);

    for (int r = 0; r < 40; r++) begin
      nlst = $urandom_range(2, 20);
      for (int i = 0; i < nlst - 1; i++) begin
        int k = $urandom_range(0, 8);
        int op = (k < 2) ? 1 : (k == 2) ? 2 : (k < 5) ? 3 : (k == 5) ? 4 : 5;
        if ($urandom_range(0, 39) == 0) op = 6;
        lst[i] = mk(op, $urandom_range(0, 6), $urandom_range(0, 65535));
      end
      lst[nlst-1] = mk(0, 0, 0);
      sl_delay = $urandom_range(0, 5);
      sl_ss_at = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 8) : NONE;
      sl_dead_at = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 10) : NONE;
      rdy_pct = $urandom_range(20, 100);
      pipe_k = $urandom_range(0, 5);
      run("random", 1'b0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule